// File: doc/BRIEF.md
# Single-Precision Float to Integer Converter

This unit takes an IEEE-754 single-precision operand and turns it into a 32-bit or 64-bit integer, signed or unsigned. The result is always delivered as a 64-bit word. A 32-bit signed outcome is sign-extended into that word and a 32-bit unsigned outcome is zero-extended. A three-bit behaviour select chooses how values that cannot be represented are handled. One family saturates and sends NaN to the type minimum. A second saturates and sends NaN to zero. A third wraps the exact integer modulo 2^N, the way scripting-language number-to-integer conversion works. The remaining codes are rejected as illegal.

Rounding follows a two-bit rounding field. The lowest bit of the behaviour select forces truncation whatever that field says. Alongside the integer the unit reports several indications: an overflow, an invalid-conversion flag, a signalling-NaN flag, an inexact flag, and fraction-rounded and fraction-inexact flags. When invalid-operation trapping is enabled and the operation is invalid, the write enable for the destination drops. All outputs are registered once, so a result appears one clock after its operands.

Top module: `f2i_convert`

## Requirements
- R1: `kind_sel` encodes 0 = signed 32-bit, 1 = unsigned 32-bit, 2 = signed 64-bit, 3 = unsigned 64-bit. A 32-bit signed result occupies `int_out` sign-extended from bit 31, and a 32-bit unsigned result is zero-extended.
- R2: The effective rounding is toward zero when `mode_sel[0]` is 1 or `rn_field` is 01. Otherwise `rn_field` 00 rounds to nearest with ties to even, 10 rounds toward +infinity and 11 rounds toward -infinity.
- R3: For `mode_sel` 0 and 1, a NaN yields the minimum of the selected type. A rounded value above the type maximum yields the maximum, and one below the type minimum yields the minimum. An in-range value yields the rounded integer.
- R4: For `mode_sel` 2 and 3, a NaN yields zero, and all other values saturate exactly as in R3.
- R5: For `mode_sel` 4 and 5, infinities and NaNs yield zero. Any other value is rounded, converted to an exact two's-complement integer, and its low 32 or 64 bits are kept before the extension of R1.
- R6: `mode_sel` 6 and 7 raise `mode_ill`. For these codes `int_out` is zero and `wr_en` and every flag are 0.
- R7: For a NaN, or when the integer represented by `int_out` under the selected type differs from the rounded value, `ovf` and `inv_cvt` are 1 and `inexact` and `frac_rnd` are 0.
- R8: Otherwise, `inexact` is 1 exactly when the integer differs from the operand. The internal rounded-up indication is 1 exactly when the integer's magnitude exceeds the operand's magnitude.
- R9: `inv_snan` is 1 exactly when the exponent field is all ones, the fraction is nonzero and fraction bit 22 is 0.
- R10: When `inv_trap_en` is 1 and `inv_cvt` or `inv_snan` is set, `wr_en` is 0 and `frac_rnd` and `frac_inx` are 0. Otherwise `wr_en` is 1, `frac_rnd` carries the rounded-up indication and `frac_inx` carries `inexact`.
- R11: Subnormal operands are not flushed. They are rounded as values below 1 in magnitude, so the smallest positive subnormal rounds to 1 toward +infinity.
- R12: All outputs are registered, with results visible one clock after the operands. A synchronous active-high `rst` clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fp_in | input | 32 | Single-precision operand |
| kind_sel | input | 2 | Integer type select |
| mode_sel | input | 3 | Out-of-range behaviour and truncation select |
| rn_field | input | 2 | Rounding field |
| inv_trap_en | input | 1 | Invalid-operation trap enable |
| int_out | output | 64 | Converted integer |
| wr_en | output | 1 | Destination write enable |
| ovf | output | 1 | Value not preserved |
| inv_cvt | output | 1 | Invalid conversion |
| inv_snan | output | 1 | Signalling-NaN operand |
| inexact | output | 1 | Integer differs from operand |
| frac_rnd | output | 1 | Fraction rounded up (masked by trap) |
| frac_inx | output | 1 | Fraction inexact (masked by trap) |
| mode_ill | output | 1 | Illegal behaviour code |

## Verification
The main sweep covers every sign, every fraction pattern from a small set (zero, lowest bit, quarter, half, three quarters, all ones), and a band of exponents. The band runs from subnormals through the sub-unity range and the 2^31/2^32 and 2^63/2^64 limits, up to infinity and NaN. Each operand is tried under every type, behaviour code and rounding field. The half and three-quarter fractions near exponent 127 separate ties-to-even from the directed roundings. The exponents around 158, 159, 190 and 191 separate in-range results from saturation and from wrapping. The all-ones exponent with different fractions separates infinity, quiet NaN and signalling NaN. Directed cases then pin exact integers for ties, for the smallest subnormal under each direction, and for the modular wrap of plus and minus three billion.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;

    localparam int FP_W    = 32;
    localparam int EXP_W   = 8;
    localparam int MAN_W   = 23;
    localparam int INT_W   = 64;
    localparam int WIDE_W  = 128;

    localparam int SIG_W   = MAN_W + 1;
    localparam int HALF_W  = INT_W / 2;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    // exponent at which the least significant significand bit weighs 1
    localparam int UNIT_E  = BIAS + MAN_W;
    // guard window below the binary point for right shifts
    localparam int GRD_W   = 32;
    localparam int WIN_W   = SIG_W + GRD_W;
    // largest right shift still handled by the window
    localparam int RSH_MAX = SIG_W + 1;

    typedef enum logic [1:0] {
        IK_S32 = 2'd0,
        IK_U32 = 2'd1,
        IK_S64 = 2'd2,
        IK_U64 = 2'd3
    } int_kind_e;

    typedef enum logic [1:0] {
        RM_NEAR = 2'd0,
        RM_ZERO = 2'd1,
        RM_UP   = 2'd2,
        RM_DOWN = 2'd3
    } round_e;

    typedef enum logic [1:0] {
        SEM_NAN_MIN  = 2'd0,
        SEM_NAN_ZERO = 2'd1,
        SEM_WRAP     = 2'd2,
        SEM_BAD      = 2'd3
    } sem_e;

    typedef struct packed {
        logic              sign;
        logic              is_nan;
        logic              is_inf;
        logic              is_snan;
        logic              exact;
        logic              bumped;
        logic [WIDE_W-1:0] mag;
    } rnd_t;

    typedef struct packed {
        logic we;
        logic ovf;
        logic cvi;
        logic snan;
        logic xx;
        logic fr;
        logic fi;
        logic bad;
    } stat_t;

    function automatic logic kind_signed(int_kind_e k);
        return ~k[0];
    endfunction

    function automatic int kind_width(int_kind_e k);
        return k[1] ? INT_W : HALF_W;
    endfunction

    // largest positive magnitude of the type
    function automatic logic [WIDE_W-1:0] pos_limit(int_kind_e k);
        logic [WIDE_W-1:0] one;
        one = WIDE_W'(1);
        return (one << (kind_width(k) - (kind_signed(k) ? 1 : 0))) - one;
    endfunction

    // largest negative magnitude of the type
    function automatic logic [WIDE_W-1:0] neg_limit(int_kind_e k);
        logic [WIDE_W-1:0] one;
        one = WIDE_W'(1);
        return kind_signed(k) ? (one << (kind_width(k) - 1)) : '0;
    endfunction

    function automatic logic [INT_W-1:0] extend(int_kind_e k, logic [INT_W-1:0] v);
        logic [INT_W-1:0] r;
        case (k)
            IK_S32:  r = {{HALF_W{v[HALF_W-1]}}, v[HALF_W-1:0]};
            IK_U32:  r = {{HALF_W{1'b0}}, v[HALF_W-1:0]};
            default: r = v;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fcvt_round.sv
module fcvt_round
    import fcvt_pkg::*;
(
    input  logic [FP_W-1:0] op,
    input  round_e          rmode,
    output rnd_t            rnd
);

    localparam logic [EXP_W:0] UNIT_EXP = (EXP_W + 1)'(UNIT_E);
    localparam logic [EXP_W:0] RSH_LIM  = (EXP_W + 1)'(RSH_MAX);

    logic               sgn;
    logic [EXP_W-1:0]   expo;
    logic [MAN_W-1:0]   man;
    logic               exp_ones;
    logic               exp_zero;
    logic [SIG_W-1:0]   sig;
    logic [EXP_W:0]     eff_e;
    logic [EXP_W:0]     lsh;
    logic [EXP_W:0]     rsh;
    logic               left_path;
    logic [WIDE_W-1:0]  big_int;
    logic [WIN_W-1:0]   win;
    logic [WIDE_W-1:0]  base;
    logic               half;
    logic               sticky;
    logic               bump;

    assign {sgn, expo, man} = op;

    always_comb begin
        exp_ones  = &expo;
        exp_zero  = ~|expo;
        sig       = {~exp_zero, man};
        // subnormals share the scale of the smallest normal exponent
        eff_e     = exp_zero ? (EXP_W + 1)'(1) : {1'b0, expo};
        left_path = (eff_e >= UNIT_EXP);
        lsh       = eff_e - UNIT_EXP;
        rsh       = UNIT_EXP - eff_e;
        big_int   = WIDE_W'(sig) << lsh;
        win       = {sig, {GRD_W{1'b0}}} >> rsh;

        if (left_path) begin
            base   = big_int;
            half   = 1'b0;
            sticky = 1'b0;
        end else if (rsh <= RSH_LIM) begin
            base   = WIDE_W'(win[WIN_W-1:GRD_W]);
            half   = win[GRD_W-1];
            sticky = |win[GRD_W-2:0];
        end else begin
            base   = '0;
            half   = 1'b0;
            sticky = |sig;
        end

        case (rmode)
            RM_NEAR: bump = half & (sticky | base[0]);
            RM_UP:   bump = ~sgn & (half | sticky);
            RM_DOWN: bump = sgn & (half | sticky);
            default: bump = 1'b0;
        endcase

        rnd.sign    = sgn;
        rnd.is_nan  = exp_ones & (|man);
        rnd.is_inf  = exp_ones & ~(|man);
        rnd.is_snan = exp_ones & (|man) & ~man[MAN_W-1];
        rnd.exact   = ~(half | sticky);
        rnd.bumped  = bump;
        rnd.mag     = base + WIDE_W'(bump);
    end

endmodule

// File: rtl/fcvt_select.sv
module fcvt_select
    import fcvt_pkg::*;
(
    input  logic              sign,
    input  logic              is_nan,
    input  logic              is_inf,
    input  logic [WIDE_W-1:0] mag,
    input  int_kind_e         kind,
    input  sem_e              sem,
    output logic [INT_W-1:0]  res
);

    logic [WIDE_W-1:0] lim_hi;
    logic [WIDE_W-1:0] lim_lo;
    logic [WIDE_W-1:0] lo_twos;
    logic [WIDE_W-1:0] twos;
    logic [INT_W-1:0]  hi_bits;
    logic [INT_W-1:0]  lo_bits;
    logic [INT_W-1:0]  raw;
    logic              neg;

    always_comb begin
        lim_hi  = pos_limit(kind);
        lim_lo  = neg_limit(kind);
        lo_twos = -lim_lo;
        hi_bits = lim_hi[INT_W-1:0];
        lo_bits = lo_twos[INT_W-1:0];
        neg     = sign & (is_inf | (|mag));
        twos    = sign ? -mag : mag;

        case (sem)
            SEM_WRAP: raw = (is_nan | is_inf) ? '0 : twos[INT_W-1:0];
            SEM_BAD:  raw = '0;
            default: begin
                if (is_nan)
                    raw = (sem == SEM_NAN_MIN) ? lo_bits : '0;
                else if (!neg)
                    raw = (is_inf | (mag > lim_hi)) ? hi_bits : mag[INT_W-1:0];
                else
                    raw = (is_inf | (mag > lim_lo)) ? lo_bits : twos[INT_W-1:0];
            end
        endcase

        res = extend(kind, raw);
    end

endmodule

// File: rtl/fcvt_flags.sv
module fcvt_flags
    import fcvt_pkg::*;
(
    input  rnd_t             rnd,
    input  int_kind_e        kind,
    input  sem_e             sem,
    input  logic             trap_en,
    input  logic [INT_W-1:0] res,
    output stat_t            st
);

    logic             fin_neg;
    logic [INT_W-1:0] fin_mag;
    logic             same;
    logic             invalid;
    logic             trap;
    logic             fr_raw;

    always_comb begin
        // integer carried by the result word, as sign and magnitude
        fin_neg = kind_signed(kind) & res[INT_W-1];
        fin_mag = fin_neg ? -res : res;
        same    = ~rnd.is_nan & ~rnd.is_inf
                & ({{(WIDE_W-INT_W){1'b0}}, fin_mag} == rnd.mag)
                & ((fin_neg == rnd.sign) | ~(|rnd.mag));
        invalid = ~same;
        trap    = trap_en & (invalid | rnd.is_snan);
        fr_raw  = ~invalid & rnd.bumped;

        st = '0;
        if (sem == SEM_BAD) begin
            st.bad = 1'b1;
        end else begin
            st.ovf  = invalid;
            st.cvi  = invalid;
            st.snan = rnd.is_snan;
            st.xx   = ~invalid & ~rnd.exact;
            st.we   = ~trap;
            st.fr   = ~trap & fr_raw;
            st.fi   = ~trap & ~invalid & ~rnd.exact;
        end
    end

endmodule

// File: rtl/f2i_convert.sv
module f2i_convert
    import fcvt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [FP_W-1:0]  fp_in,
    input  logic [1:0]       kind_sel,
    input  logic [2:0]       mode_sel,
    input  logic [1:0]       rn_field,
    input  logic             inv_trap_en,
    output logic [INT_W-1:0] int_out,
    output logic             wr_en,
    output logic             ovf,
    output logic             inv_cvt,
    output logic             inv_snan,
    output logic             inexact,
    output logic             frac_rnd,
    output logic             frac_inx,
    output logic             mode_ill
);

    int_kind_e        kind;
    sem_e             sem;
    round_e           rmode;
    rnd_t             rnd;
    logic [INT_W-1:0] res_d;
    stat_t            st_d;

    always_comb begin
        kind  = int_kind_e'(kind_sel);
        sem   = sem_e'(mode_sel[2:1]);
        rmode = (mode_sel[0] || rn_field == 2'b01) ? RM_ZERO : round_e'(rn_field);
    end

    fcvt_round u_round (
        .op    (fp_in),
        .rmode (rmode),
        .rnd   (rnd)
    );

    fcvt_select u_select (
        .sign   (rnd.sign),
        .is_nan (rnd.is_nan),
        .is_inf (rnd.is_inf),
        .mag    (rnd.mag),
        .kind   (kind),
        .sem    (sem),
        .res    (res_d)
    );

    fcvt_flags u_flags (
        .rnd     (rnd),
        .kind    (kind),
        .sem     (sem),
        .trap_en (inv_trap_en),
        .res     (res_d),
        .st      (st_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            int_out  <= '0;
            wr_en    <= 1'b0;
            ovf      <= 1'b0;
            inv_cvt  <= 1'b0;
            inv_snan <= 1'b0;
            inexact  <= 1'b0;
            frac_rnd <= 1'b0;
            frac_inx <= 1'b0;
            mode_ill <= 1'b0;
        end else begin
            int_out  <= res_d;
            wr_en    <= st_d.we;
            ovf      <= st_d.ovf;
            inv_cvt  <= st_d.cvi;
            inv_snan <= st_d.snan;
            inexact  <= st_d.xx;
            frac_rnd <= st_d.fr;
            frac_inx <= st_d.fi;
            mode_ill <= st_d.bad;
        end
    end

    // R1: 32-bit signed results are sign-extended
    p_ext_s32_r1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(kind_sel) == 2'd0)
            |-> int_out[INT_W-1:HALF_W] == {HALF_W{int_out[HALF_W-1]}});

    // R1: 32-bit unsigned results are zero-extended
    p_ext_u32_r1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(kind_sel) == 2'd1)
            |-> int_out[INT_W-1:HALF_W] == '0);

    // R3: NaN in the first family gives the signed 64-bit minimum
    p_nan_min_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(fp_in[30:23]) == 8'hFF && $past(fp_in[22:0]) != '0
            && $past(mode_sel[2:1]) == 2'b00 && $past(kind_sel) == 2'd2)
            |-> int_out == {1'b1, {(INT_W-1){1'b0}}});

    // R4: NaN in the second family gives zero
    p_nan_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(fp_in[30:23]) == 8'hFF && $past(fp_in[22:0]) != '0
            && $past(mode_sel[2:1]) == 2'b01)
            |-> int_out == '0);

    // R6: illegal codes produce nothing
    p_bad_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        mode_ill |-> (int_out == '0 && !wr_en && !ovf && !inv_cvt && !inv_snan
                      && !inexact && !frac_rnd && !frac_inx));

    // R7: overflow excludes inexact and rounded-up
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        ovf |-> (inv_cvt && !inexact && !frac_rnd && !frac_inx));

    // R8: rounding up always makes the result inexact
    p_fr_inexact_r8: assert property (@(posedge clk) disable iff (rst)
        frac_rnd |-> (frac_inx && inexact));

    // R9: a signalling NaN is also an invalid conversion
    p_snan_cvi_r9: assert property (@(posedge clk) disable iff (rst)
        inv_snan |-> inv_cvt);

    // R10: a suppressed write only follows an enabled invalid operation
    p_trap_r10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !wr_en && !mode_ill)
            |-> ($past(inv_trap_en) && (inv_cvt || inv_snan) && !frac_rnd && !frac_inx));

endmodule

// File: tb/f2i_convert_bench.sv
module f2i_convert_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] fp_in = '0;
    logic [1:0]  kind_sel = '0;
    logic [2:0]  mode_sel = '0;
    logic [1:0]  rn_field = '0;
    logic        inv_trap_en = 1'b0;
    logic [63:0] int_out;
    logic        wr_en, ovf, inv_cvt, inv_snan, inexact, frac_rnd, frac_inx, mode_ill;

    int n_cmp = 0;
    int n_bad = 0;

    localparam int WD_CYC = 190000;

    always #10 clk = ~clk;

    f2i_convert u_f2i_convert (
        .clk(clk), .rst(rst), .fp_in(fp_in), .kind_sel(kind_sel), .mode_sel(mode_sel),
        .rn_field(rn_field), .inv_trap_en(inv_trap_en), .int_out(int_out), .wr_en(wr_en),
        .ovf(ovf), .inv_cvt(inv_cvt), .inv_snan(inv_snan), .inexact(inexact),
        .frac_rnd(frac_rnd), .frac_inx(frac_inx), .mode_ill(mode_ill)
    );

    task automatic cmp(input string tag, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [127:0] to_u128(input real x);
        logic [127:0] q;
        real t;
        q = '0;
        t = x;
        for (int i = 127; i >= 0; i--) begin
            real p;
            p = 2.0 ** i;
            if (t >= p) begin
                q[i] = 1'b1;
                t = t - p;
            end
        end
        return q;
    endfunction

    function automatic real round_int(input real v, input int rm);
        real fl, d, r;
        fl = $floor(v);
        d  = v - fl;
        case (rm)
            1: r = (v >= 0.0) ? fl : $ceil(v);
            2: r = $ceil(v);
            3: r = fl;
            default: begin
                if (d > 0.5) r = fl + 1.0;
                else if (d < 0.5) r = fl;
                else r = ($floor(fl / 2.0) * 2.0 == fl) ? fl : fl + 1.0;
            end
        endcase
        return r;
    endfunction

    function automatic logic [63:0] ext_kind(input logic [1:0] k, input logic [63:0] v);
        if (k == 2'd0) return {{32{v[31]}}, v[31:0]};
        if (k == 2'd1) return {32'b0, v[31:0]};
        return v;
    endfunction

    // arithmetic reference built from the requirement text
    task automatic model(input logic [31:0] b, input logic [1:0] k, input logic [2:0] m,
                         input logic [1:0] rn, input logic en, output logic [63:0] er,
                         output logic ewe, output logic eovf, output logic esnan,
                         output logic exx, output logic efr, output logic efi,
                         output logic ebad);
        int ee, ff, bits, rm;
        logic nan, inf, snan, sgnd, fneg, rneg, trap;
        real v, r, up, lo, av, ar;
        logic [63:0] maxb, minb, fmag;
        logic [127:0] rmag, tc;
        ee = int'(b[30:23]);
        ff = int'(b[22:0]);
        nan  = (ee == 255) && (ff != 0);
        inf  = (ee == 255) && (ff == 0);
        snan = nan && !b[22];
        er = '0; ewe = 0; eovf = 0; esnan = 0; exx = 0; efr = 0; efi = 0; ebad = 0;
        if (m >= 3'd6) begin
            ebad = 1;
            return;
        end
        rm   = (m[0] || rn == 2'b01) ? 1 : int'(rn);
        bits = k[1] ? 64 : 32;
        sgnd = !k[0];
        v = 0.0;
        r = 0.0;
        if (!nan && !inf) begin
            v = real'(ee == 0 ? ff : ff + 8388608) * (2.0 ** real'((ee == 0 ? 1 : ee) - 150));
            if (b[31]) v = -v;
            r = round_int(v, rm);
        end
        if (sgnd) begin
            up = 2.0 ** (bits - 1);
            lo = -up;
            maxb = (bits == 64) ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h0000_0000_7FFF_FFFF;
            minb = (bits == 64) ? 64'h8000_0000_0000_0000 : 64'hFFFF_FFFF_8000_0000;
        end else begin
            up = 2.0 ** bits;
            lo = 0.0;
            maxb = (bits == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
            minb = '0;
        end
        ar   = (r < 0.0) ? -r : r;
        av   = (v < 0.0) ? -v : v;
        rmag = to_u128(ar);
        rneg = (r < 0.0);
        tc   = rneg ? -rmag : rmag;
        if (m < 3'd4) begin
            if (nan)           er = (m < 3'd2) ? minb : '0;
            else if (inf)      er = b[31] ? minb : maxb;
            else if (r >= up)  er = maxb;
            else if (r < lo)   er = minb;
            else               er = tc[63:0];
        end else begin
            er = (nan || inf) ? '0 : tc[63:0];
        end
        er = ext_kind(k, er);
        fneg = sgnd && er[63];
        fmag = fneg ? -er : er;
        eovf = nan || inf || ({64'b0, fmag} != rmag) || (fneg != rneg);
        esnan = snan;
        exx  = !eovf && (r != v);
        trap = en && (eovf || snan);
        ewe  = !trap;
        efr  = !trap && !eovf && (ar > av);
        efi  = !trap && exx;
    endtask

    task automatic drive(input logic [31:0] b, input logic [1:0] k, input logic [2:0] m,
                         input logic [1:0] rn, input logic en);
        fp_in = b; kind_sel = k; mode_sel = m; rn_field = rn; inv_trap_en = en;
        @(negedge clk);
    endtask

    task automatic sweep_one(input logic [31:0] b, input logic [1:0] k, input logic [2:0] m,
                             input logic [1:0] rn, input logic en);
        logic [63:0] er;
        logic ewe, eovf, esnan, exx, efr, efi, ebad;
        string rtag;
        model(b, k, m, rn, en, er, ewe, eovf, esnan, exx, efr, efi, ebad);
        drive(b, k, m, rn, en);
        if (m < 3'd2)      rtag = "R3";
        else if (m < 3'd4) rtag = "R4";
        else if (m < 3'd6) rtag = "R5";
        else               rtag = "R6";
        cmp(rtag,  $sformatf("int_out op=%h k=%0d m=%0d rn=%0d", b, k, m, rn), int_out, er);
        cmp("R10", "wr_en",    64'(wr_en),    64'(ewe));
        cmp("R7",  "ovf",      64'(ovf),      64'(eovf));
        cmp("R7",  "inv_cvt",  64'(inv_cvt),  64'(eovf));
        cmp("R9",  "inv_snan", 64'(inv_snan), 64'(esnan));
        cmp("R8",  "inexact",  64'(inexact),  64'(exx));
        cmp("R10", "frac_rnd", 64'(frac_rnd), 64'(efr));
        cmp("R10", "frac_inx", 64'(frac_inx), 64'(efi));
        cmp("R6",  "mode_ill", 64'(mode_ill), 64'(ebad));
    endtask

    task automatic dir(input string tag, input logic [31:0] b, input logic [1:0] k,
                       input logic [2:0] m, input logic [1:0] rn, input logic en,
                       input logic [63:0] exp_res, input logic exp_ovf);
        drive(b, k, m, rn, en);
        cmp(tag, $sformatf("int_out op=%h", b), int_out, exp_res);
        cmp(tag, "ovf", 64'(ovf), 64'(exp_ovf));
    endtask

    function automatic logic keep_exp(input int e);
        return (e <= 1) || (e == 100) || (e >= 120 && e <= 160) || (e >= 188 && e <= 192)
            || (e == 220) || (e >= 254);
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(WD_CYC * 20);
        n_bad++;
        $display("FAIL R12 watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        logic [22:0] fr_set [6];
        fr_set = '{23'h000000, 23'h000001, 23'h200000, 23'h400000, 23'h600000, 23'h7FFFFF};
        repeat (3) @(negedge clk);
        // R12: reset clears every output
        cmp("R12", "reset int_out", int_out, '0);
        cmp("R12", "reset flags",
            64'({wr_en, ovf, inv_cvt, inv_snan, inexact, frac_rnd, frac_inx, mode_ill}), 64'(0));
        rst = 1'b0;

        // R2: ties and directions, truncation forced by odd mode
        dir("R2", 32'h40200000, 2'd2, 3'd0, 2'd0, 1'b0, 64'd2, 1'b0);
        dir("R2", 32'h40200000, 2'd2, 3'd0, 2'd1, 1'b0, 64'd2, 1'b0);
        dir("R2", 32'h40200000, 2'd2, 3'd0, 2'd2, 1'b0, 64'd3, 1'b0);
        dir("R2", 32'h40200000, 2'd2, 3'd0, 2'd3, 1'b0, 64'd2, 1'b0);
        dir("R2", 32'h40200000, 2'd2, 3'd1, 2'd2, 1'b0, 64'd2, 1'b0);
        dir("R2", 32'hC0200000, 2'd2, 3'd0, 2'd3, 1'b0, 64'hFFFF_FFFF_FFFF_FFFD, 1'b0);
        dir("R2", 32'h40600000, 2'd2, 3'd0, 2'd0, 1'b0, 64'd4, 1'b0);
        // R11: smallest subnormal is rounded, not flushed
        dir("R11", 32'h00000001, 2'd2, 3'd0, 2'd2, 1'b0, 64'd1, 1'b0);
        cmp("R11", "frac_rnd", 64'(frac_rnd), 64'(1));
        cmp("R11", "frac_inx", 64'(frac_inx), 64'(1));
        dir("R11", 32'h80000001, 2'd2, 3'd0, 2'd3, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        dir("R11", 32'h80000001, 2'd2, 3'd0, 2'd0, 1'b0, 64'd0, 1'b0);
        cmp("R11", "inexact", 64'(inexact), 64'(1));
        // R1: type encoding and extension
        dir("R1", 32'hBF800000, 2'd0, 3'd0, 2'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        dir("R1", 32'hBF800000, 2'd1, 3'd0, 2'd0, 1'b0, 64'd0, 1'b1);
        dir("R1", 32'h4F000000, 2'd0, 3'd0, 2'd0, 1'b0, 64'h0000_0000_7FFF_FFFF, 1'b1);
        cmp("R7", "inexact on overflow", 64'(inexact), 64'(0));
        dir("R1", 32'h4F000000, 2'd1, 3'd0, 2'd0, 1'b0, 64'h0000_0000_8000_0000, 1'b0);
        // R3 / R4: NaN handling
        dir("R3", 32'h7FC00000, 2'd0, 3'd0, 2'd0, 1'b0, 64'hFFFF_FFFF_8000_0000, 1'b1);
        dir("R3", 32'h7FC00000, 2'd1, 3'd1, 2'd0, 1'b0, 64'd0, 1'b1);
        dir("R3", 32'h7FC00000, 2'd2, 3'd0, 2'd0, 1'b0, 64'h8000_0000_0000_0000, 1'b1);
        dir("R4", 32'h7FC00000, 2'd2, 3'd2, 2'd0, 1'b0, 64'd0, 1'b1);
        dir("R4", 32'h7F800000, 2'd3, 3'd3, 2'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
        // R5: modular wrap
        dir("R5", 32'h4F32D05E, 2'd0, 3'd4, 2'd0, 1'b0, 64'hFFFF_FFFF_B2D0_5E00, 1'b1);
        dir("R5", 32'h4F32D05E, 2'd1, 3'd4, 2'd0, 1'b0, 64'h0000_0000_B2D0_5E00, 1'b0);
        dir("R5", 32'h4F800000, 2'd0, 3'd5, 2'd0, 1'b0, 64'd0, 1'b1);
        dir("R5", 32'hFF800000, 2'd2, 3'd4, 2'd0, 1'b0, 64'd0, 1'b1);
        dir("R5", 32'hCF32D05E, 2'd2, 3'd4, 2'd0, 1'b0, 64'hFFFF_FFFF_4D2F_A200, 1'b0);
        // R6: illegal codes
        dir("R6", 32'h3FC00000, 2'd2, 3'd6, 2'd0, 1'b0, 64'd0, 1'b0);
        cmp("R6", "mode_ill", 64'(mode_ill), 64'(1));
        cmp("R6", "wr_en", 64'(wr_en), 64'(0));
        // R9 / R10: signalling NaN and trapping
        dir("R9", 32'h7F800001, 2'd2, 3'd0, 2'd0, 1'b1, 64'h8000_0000_0000_0000, 1'b1);
        cmp("R9", "inv_snan", 64'(inv_snan), 64'(1));
        cmp("R10", "wr_en trapped", 64'(wr_en), 64'(0));
        dir("R10", 32'h7FC00000, 2'd2, 3'd0, 2'd0, 1'b1, 64'h8000_0000_0000_0000, 1'b1);
        cmp("R9", "inv_snan quiet", 64'(inv_snan), 64'(0));
        cmp("R10", "wr_en trapped", 64'(wr_en), 64'(0));
        dir("R10", 32'h3FC00000, 2'd2, 3'd0, 2'd0, 1'b1, 64'd2, 1'b0);
        cmp("R10", "wr_en", 64'(wr_en), 64'(1));
        cmp("R10", "frac_rnd", 64'(frac_rnd), 64'(1));
        // R8: inexact without rounding up, and exact
        dir("R8", 32'h3FA00000, 2'd2, 3'd0, 2'd0, 1'b0, 64'd1, 1'b0);
        cmp("R8", "inexact", 64'(inexact), 64'(1));
        cmp("R8", "frac_rnd", 64'(frac_rnd), 64'(0));
        dir("R8", 32'h40000000, 2'd2, 3'd0, 2'd0, 1'b0, 64'd2, 1'b0);
        cmp("R8", "inexact exact", 64'(inexact), 64'(0));

        // sweep
        for (int e = 0; e < 256; e++) begin
            if (!keep_exp(e)) continue;
            for (int fi = 0; fi < 6; fi++) begin
                for (int s = 0; s < 2; s++) begin
                    for (int k = 0; k < 4; k++) begin
                        for (int m = 0; m < 8; m++) begin
                            for (int rn = 0; rn < 4; rn++) begin
                                sweep_one({s[0], e[7:0], fr_set[fi]}, k[1:0], m[2:0],
                                          rn[1:0], (e[0] ^ fi[0] ^ k[1]));
                            end
                        end
                    end
                end
            end
        end

        summary();
        $finish;
    end

endmodule